// File: doc/BRIEF.md
# Watchdog Reset Generator with Reset-Cause Flags

This block runs a watchdog counter on the oscillator clock. Firmware must service it with a kick strobe. If the counter reaches its top value while the watchdog is enabled and no kick arrives, the block pulls an internal watchdog reset low for a fixed number of oscillator cycles.

The active-low chip reset output is the AND of three terms: that internal reset, the level of the external reset pin, and the inverse of a stretched brown-out term. The brown-out term holds reset for a set delay after the brown-out request clears.

Two sticky flags let firmware find out why the chip restarted after reset:

- The watchdog-cause flag can only be set by the release of the internal watchdog reset. A power-on, brown-out or external-pin reset therefore leaves it clear.
- The clock-fail flag records a detected oscillator failure. Chip resets do not clear it. Only power-on or its own clear strobe clears it.

The `por` input is the power-on reset, synchronous and active high. It returns all state to idle and clears both flags.

Top module: `wdr_top`

## Requirements
- R1: With `wd_en` high and no kick, `chip_rst_n` goes low 2^CNT_W cycles after the last kick edge, or after the release of a reset. It stays low for exactly PULSE_LEN cycles.
- R2: A kick clears the counter. While `wd_en` is low the counter holds at zero. In both cases no watchdog reset occurs if kicks arrive less than 2^CNT_W cycles apart.
- R3: `wd_flag` becomes 1 exactly SAMPLE_DLY cycles after the watchdog reset begins, provided the watchdog reset was released and `ext_rst_n` was high from that release up to the sample point. Nothing else sets it.
- R4: A low `ext_rst_n` clears `wd_flag` on the next clock edge. A low `ext_rst_n` at any point between the watchdog release and the sample point leaves `wd_flag` at 0.
- R5: `chip_rst_n` is low whenever `ext_rst_n` is low. While the pin is low the watchdog counter is held at zero, so it restarts from zero when the pin is released.
- R6: `chip_rst_n` is low while `bor_req` is high and for BOR_DLY more cycles after it falls. A brown-out reset never sets `wd_flag`.
- R7: `clkfail_flag` is set by `clk_fail_det`. It survives external, brown-out and watchdog resets. It is cleared by `cff_clr`, and detection wins over clear.
- R8: `por` clears both flags and leaves `chip_rst_n` high. `wdf_clr` clears `wd_flag` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| wd_en | input | 1 | Watchdog enable |
| kick | input | 1 | Service strobe, clears the counter |
| ext_rst_n | input | 1 | External reset pin level, active low |
| bor_req | input | 1 | Brown-out request, active high |
| clk_fail_det | input | 1 | Oscillator failure detected |
| wdf_clr | input | 1 | Clear strobe for the watchdog-cause flag |
| cff_clr | input | 1 | Clear strobe for the clock-fail flag |
| chip_rst_n | output | 1 | Combined chip reset, active low |
| wd_flag | output | 1 | Sticky watchdog-cause flag |
| clkfail_flag | output | 1 | Sticky clock-fail flag |

## Verification
The fault classes below each show up at the ports:

- **Counter off by one.** The reset arrives a cycle early or late after a kick, so the bench samples the cycle before and the cycle of the expected edge.
- **Wrong pulse counter.** The low time of `chip_rst_n` differs from PULSE_LEN, which the bench counts cycle by cycle.
- **Wrong sample window or pending state.** The flag appears at the wrong cycle, or appears after external and brown-out resets. The bench samples the flag one cycle before and at the sample point, and long after every non-watchdog reset.
- **Hold or stretch counter not cleared.** This shows as a shifted overflow after pin release, or as a wrong brown-out release cycle, on the very first cycle involved.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

    typedef enum logic {
        WD_RUN   = 1'b0,
        WD_PULSE = 1'b1
    } wd_state_e;

    localparam int DEF_CNT_W      = 8;
    localparam int DEF_PULSE_LEN  = 512;
    localparam int DEF_SAMPLE_DLY = 8192 * 4 + 512;
    localparam int DEF_BOR_DLY    = 400;

    function automatic int cnt_bits(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/wdr_timer.sv
module wdr_timer
    import wdr_pkg::*;
#(
    parameter int CNT_W     = DEF_CNT_W,
    parameter int PULSE_LEN = DEF_PULSE_LEN
) (
    input  logic clk,
    input  logic por,
    input  logic en,
    input  logic kick,
    input  logic hold,
    output logic wd_rst_n,
    output logic wd_start,
    output logic wd_release
);
    localparam int PW = cnt_bits(PULSE_LEN);

    wd_state_e        st;
    logic [CNT_W-1:0] cnt;
    logic [PW-1:0]    pls;
    logic             at_max;

    assign at_max     = &cnt;
    assign wd_start   = (st == WD_RUN) && en && !kick && !hold && at_max;
    assign wd_release = (st == WD_PULSE) && (pls == PW'(PULSE_LEN - 1));
    assign wd_rst_n   = (st != WD_PULSE);

    always_ff @(posedge clk) begin
        if (por) begin
            st  <= WD_RUN;
            cnt <= '0;
            pls <= '0;
        end else begin
            case (st)
                WD_RUN: begin
                    if (hold || !en || kick) begin
                        cnt <= '0;
                    end else if (at_max) begin
                        cnt <= '0;
                        pls <= '0;
                        st  <= WD_PULSE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    cnt <= '0;
                    if (wd_release) begin
                        st  <= WD_RUN;
                        pls <= '0;
                    end else begin
                        pls <= pls + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/wdr_bor.sv
module wdr_bor
    import wdr_pkg::*;
#(
    parameter int BOR_DLY = DEF_BOR_DLY
) (
    input  logic clk,
    input  logic por,
    input  logic bor_req,
    output logic bor_active
);
    localparam int BW = cnt_bits(BOR_DLY);

    logic [BW-1:0] dly;

    always_ff @(posedge clk) begin
        if (por)
            dly <= '0;
        else if (bor_req)
            dly <= BW'(BOR_DLY);
        else if (dly != '0)
            dly <= dly - 1'b1;
    end

    assign bor_active = bor_req || (dly != '0);
endmodule

// File: rtl/wdr_flags.sv
module wdr_flags
    import wdr_pkg::*;
#(
    parameter int SAMPLE_DLY = DEF_SAMPLE_DLY
) (
    input  logic clk,
    input  logic por,
    input  logic wd_start,
    input  logic wd_release,
    input  logic ext_rst_n,
    input  logic clk_fail_det,
    input  logic wdf_clr,
    input  logic cff_clr,
    output logic wd_flag,
    output logic clkfail_flag
);
    localparam int WW = cnt_bits(SAMPLE_DLY);

    logic          win_act;
    logic [WW-1:0] win_cnt;
    logic          pending;
    logic          at_sample;

    assign at_sample = win_act && (win_cnt == WW'(SAMPLE_DLY - 1));

    // Sample window measured from the start of the watchdog pulse.
    always_ff @(posedge clk) begin
        if (por) begin
            win_act <= 1'b0;
            win_cnt <= '0;
        end else if (wd_start) begin
            win_act <= 1'b1;
            win_cnt <= '0;
        end else if (win_act) begin
            win_cnt <= win_cnt + 1'b1;
            if (at_sample)
                win_act <= 1'b0;
        end
    end

    // The release edge arms the flag; any pin low disarms it.
    always_ff @(posedge clk) begin
        if (por)
            pending <= 1'b0;
        else if (!ext_rst_n || wd_start || at_sample)
            pending <= 1'b0;
        else if (wd_release)
            pending <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (por)
            wd_flag <= 1'b0;
        else if (!ext_rst_n)
            wd_flag <= 1'b0;
        else if (at_sample && pending)
            wd_flag <= 1'b1;
        else if (wdf_clr)
            wd_flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (por)
            clkfail_flag <= 1'b0;
        else if (clk_fail_det)
            clkfail_flag <= 1'b1;
        else if (cff_clr)
            clkfail_flag <= 1'b0;
    end
endmodule

// File: rtl/wdr_top.sv
module wdr_top
    import wdr_pkg::*;
#(
    parameter int CNT_W      = DEF_CNT_W,
    parameter int PULSE_LEN  = DEF_PULSE_LEN,
    parameter int SAMPLE_DLY = DEF_SAMPLE_DLY,
    parameter int BOR_DLY    = DEF_BOR_DLY
) (
    input  logic clk,
    input  logic por,
    input  logic wd_en,
    input  logic kick,
    input  logic ext_rst_n,
    input  logic bor_req,
    input  logic clk_fail_det,
    input  logic wdf_clr,
    input  logic cff_clr,
    output logic chip_rst_n,
    output logic wd_flag,
    output logic clkfail_flag
);
    logic wd_rst_n;
    logic wd_start;
    logic wd_release;
    logic bor_active;
    logic hold;

    assign hold = !ext_rst_n || bor_active;

    wdr_timer #(
        .CNT_W     (CNT_W),
        .PULSE_LEN (PULSE_LEN)
    ) u_timer (
        .clk        (clk),
        .por        (por),
        .en         (wd_en),
        .kick       (kick),
        .hold       (hold),
        .wd_rst_n   (wd_rst_n),
        .wd_start   (wd_start),
        .wd_release (wd_release)
    );

    wdr_bor #(
        .BOR_DLY (BOR_DLY)
    ) u_bor (
        .clk        (clk),
        .por        (por),
        .bor_req    (bor_req),
        .bor_active (bor_active)
    );

    wdr_flags #(
        .SAMPLE_DLY (SAMPLE_DLY)
    ) u_flags (
        .clk          (clk),
        .por          (por),
        .wd_start     (wd_start),
        .wd_release   (wd_release),
        .ext_rst_n    (ext_rst_n),
        .clk_fail_det (clk_fail_det),
        .wdf_clr      (wdf_clr),
        .cff_clr      (cff_clr),
        .wd_flag      (wd_flag),
        .clkfail_flag (clkfail_flag)
    );

    assign chip_rst_n = wd_rst_n && ext_rst_n && !bor_active;
endmodule

// File: rtl/wdr_chk.sv
module wdr_chk #(
    parameter int PULSE_LEN = 512
) (
    input logic clk,
    input logic por,
    input logic wd_rst_n,
    input logic ext_rst_n,
    input logic bor_req,
    input logic clk_fail_det,
    input logic chip_rst_n,
    input logic wd_flag,
    input logic clkfail_flag
);
    localparam int LW = $clog2(PULSE_LEN + 2);

    logic [LW-1:0] low_cnt;
    logic          wd_prev;
    logic          seen_rel;

    always_ff @(posedge clk) begin
        if (por) begin
            low_cnt  <= '0;
            wd_prev  <= 1'b1;
            seen_rel <= 1'b0;
        end else begin
            wd_prev <= wd_rst_n;
            if (wd_rst_n)
                low_cnt <= '0;
            else if (low_cnt != LW'(PULSE_LEN + 1))
                low_cnt <= low_cnt + 1'b1;
            if (!ext_rst_n)
                seen_rel <= 1'b0;
            else if (wd_rst_n && !wd_prev)
                seen_rel <= 1'b1;
        end
    end

    a_r1_pulse_len: assert property (@(posedge clk) disable iff (por)
        $rose(wd_rst_n) |-> (low_cnt == LW'(PULSE_LEN)));

    a_r1_pulse_max: assert property (@(posedge clk) disable iff (por)
        !wd_rst_n |-> (low_cnt < LW'(PULSE_LEN)));

    a_r3_flag_needs_release: assert property (@(posedge clk) disable iff (por)
        $rose(wd_flag) |-> (seen_rel && ext_rst_n));

    a_r4_pin_clears_flag: assert property (@(posedge clk) disable iff (por)
        !ext_rst_n |=> !wd_flag);

    a_r5_pin_forces_reset: assert property (@(posedge clk) disable iff (por)
        !ext_rst_n |-> !chip_rst_n);

    a_r6_bor_forces_reset: assert property (@(posedge clk) disable iff (por)
        bor_req |-> !chip_rst_n);

    a_r7_clkfail_set: assert property (@(posedge clk) disable iff (por)
        clk_fail_det |=> clkfail_flag);
endmodule

bind wdr_top wdr_chk #(
    .PULSE_LEN (PULSE_LEN)
) u_chk (
    .clk          (clk),
    .por          (por),
    .wd_rst_n     (wd_rst_n),
    .ext_rst_n    (ext_rst_n),
    .bor_req      (bor_req),
    .clk_fail_det (clk_fail_det),
    .chip_rst_n   (chip_rst_n),
    .wd_flag      (wd_flag),
    .clkfail_flag (clkfail_flag)
);

// File: tb/sim_wdr_top.sv
`timescale 1ns/1ps
module sim_wdr_top;
    localparam int CNT_W = 4;
    localparam int PLEN  = 512;
    localparam int SDLY  = 700;
    localparam int BDLY  = 20;
    localparam int OVF   = 1 << CNT_W;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic wd_en = 1'b0, kick = 1'b0, ext_rst_n = 1'b1, bor_req = 1'b0;
    logic clk_fail_det = 1'b0, wdf_clr = 1'b0, cff_clr = 1'b0;
    logic chip_rst_n, wd_flag, clkfail_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdr_top #(
        .CNT_W (CNT_W), .PULSE_LEN (PLEN), .SAMPLE_DLY (SDLY), .BOR_DLY (BDLY)
    ) u0 (
        .clk (clk), .por (por), .wd_en (wd_en), .kick (kick),
        .ext_rst_n (ext_rst_n), .bor_req (bor_req), .clk_fail_det (clk_fail_det),
        .wdf_clr (wdf_clr), .cff_clr (cff_clr), .chip_rst_n (chip_rst_n),
        .wd_flag (wd_flag), .clkfail_flag (clkfail_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_kick();
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    // Kick, let the counter overflow, return the measured low time.
    // Leaves time at sample PLEN counted from the pulse start.
    task automatic run_wd(input string req, output int plen);
        wd_en = 1'b1;
        do_kick();
        repeat (OVF - 1) @(negedge clk);
        chk({req, " high before overflow"}, chip_rst_n, 1);
        @(negedge clk);
        chk({req, " low at overflow"}, chip_rst_n, 0);
        wd_en = 1'b0;
        plen = 1;
        while (!chip_rst_n) begin
            @(negedge clk);
            if (!chip_rst_n) plen++;
        end
    endtask

    initial begin
        int lows;
        int pl;
        repeat (3) @(negedge clk);
        por = 1'b0;
        @(negedge clk);
        // R8 reset state
        chk("R8 reset chip_rst_n", chip_rst_n, 1);
        chk("R8 reset wd_flag", wd_flag, 0);
        chk("R8 reset clkfail_flag", clkfail_flag, 0);

        // R2 disabled: no reset
        lows = 0;
        repeat (100) begin
            @(negedge clk);
            if (!chip_rst_n) lows++;
        end
        chk("R2 disabled no reset", lows, 0);

        // R2 regular kicks keep it quiet
        wd_en = 1'b1;
        lows = 0;
        for (int i = 0; i < 12; i++) begin
            do_kick();
            repeat (OVF - 4) begin
                @(negedge clk);
                if (!chip_rst_n) lows++;
            end
        end
        chk("R2 kicked no reset", lows, 0);

        // R1 + R3 watchdog reset and flag timing
        run_wd("R1", pl);
        chk("R1 pulse length", pl, PLEN);
        repeat (SDLY - PLEN - 1) @(negedge clk);
        chk("R3 flag before sample", wd_flag, 0);
        @(negedge clk);
        chk("R3 flag at sample", wd_flag, 1);

        // R8 software clear
        wdf_clr = 1'b1;
        @(negedge clk);
        wdf_clr = 1'b0;
        chk("R8 wdf_clr clears", wd_flag, 0);

        // R4 pin low briefly after release, inside window
        run_wd("R4a", pl);
        ext_rst_n = 1'b0;
        repeat (10) @(negedge clk);
        ext_rst_n = 1'b1;
        repeat (SDLY) @(negedge clk);
        chk("R4 pin low in window", wd_flag, 0);

        // R4 pin low at the sample point
        run_wd("R4b", pl);
        repeat (SDLY - PLEN - 3) @(negedge clk);
        ext_rst_n = 1'b0;
        @(negedge clk);
        chk("R5 pin low forces reset", chip_rst_n, 0);
        repeat (10) @(negedge clk);
        ext_rst_n = 1'b1;
        repeat (SDLY) @(negedge clk);
        chk("R4 pin low at sample", wd_flag, 0);

        // R5 counter held while pin low, restarts from zero
        wd_en = 1'b1;
        ext_rst_n = 1'b0;
        repeat (100) @(negedge clk);
        chk("R5 low during pin reset", chip_rst_n, 0);
        ext_rst_n = 1'b1;
        repeat (OVF - 1) @(negedge clk);
        chk("R5 held counter: high", chip_rst_n, 1);
        @(negedge clk);
        chk("R5 held counter: overflow", chip_rst_n, 0);
        wd_en = 1'b0;
        repeat (SDLY + 5) @(negedge clk);
        chk("R3 flag after wd reset", wd_flag, 1);
        ext_rst_n = 1'b0;
        @(negedge clk);
        chk("R4 pin low clears flag", wd_flag, 0);
        ext_rst_n = 1'b1;
        repeat (SDLY + 20) @(negedge clk);
        chk("R3 pin reset never sets flag", wd_flag, 0);

        // R6 brown-out
        bor_req = 1'b1;
        lows = 0;
        repeat (50) begin
            @(negedge clk);
            if (!chip_rst_n) lows++;
        end
        chk("R6 low during request", lows, 50);
        bor_req = 1'b0;
        repeat (BDLY - 1) @(negedge clk);
        chk("R6 still low before delay", chip_rst_n, 0);
        @(negedge clk);
        chk("R6 released after delay", chip_rst_n, 1);
        repeat (SDLY + 20) @(negedge clk);
        chk("R6 no flag from brown-out", wd_flag, 0);

        // R7 clock-fail flag
        clk_fail_det = 1'b1;
        @(negedge clk);
        clk_fail_det = 1'b0;
        chk("R7 set by detect", clkfail_flag, 1);
        ext_rst_n = 1'b0;
        repeat (5) @(negedge clk);
        ext_rst_n = 1'b1;
        bor_req = 1'b1;
        repeat (5) @(negedge clk);
        bor_req = 1'b0;
        repeat (BDLY + 2) @(negedge clk);
        run_wd("R7 wd", pl);
        chk("R7 survives chip resets", clkfail_flag, 1);
        cff_clr = 1'b1;
        clk_fail_det = 1'b1;
        @(negedge clk);
        clk_fail_det = 1'b0;
        chk("R7 detect wins over clear", clkfail_flag, 1);
        @(negedge clk);
        cff_clr = 1'b0;
        chk("R7 cleared by cff_clr", clkfail_flag, 0);

        // R8 power-on clears both flags
        repeat (SDLY) @(negedge clk);
        chk("R8 wd flag set before por", wd_flag, 1);
        clk_fail_det = 1'b1;
        @(negedge clk);
        clk_fail_det = 1'b0;
        por = 1'b1;
        @(negedge clk);
        por = 1'b0;
        chk("R8 por clears wd_flag", wd_flag, 0);
        chk("R8 por clears clkfail_flag", clkfail_flag, 0);
        chk("R8 chip_rst_n high after por", chip_rst_n, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule